// File: doc/BRIEF.md
# Port Controller Command Decoder with Buffer Pointers

This block sits behind the register interface of a USB Type-C port controller. Software writes one byte into a command slot, and the block decodes it. Each recognised code changes a piece of the port's control state: VBUS detection, the sink path, the source path at default or high voltage, and connection searching. Other codes move the transmit and receive buffer pointers or arm a one-shot receiver option. The buffer memories and the analog power switches stay outside. The block drives the level signals that control them, and it keeps the byte pointers that the buffer logic uses for addressing.

A two-state machine handles each command. In `CMD_IDLE` it waits. A command strobe stores the byte and moves it to `CMD_EXEC` (transition IDLE_TO_EXEC). In `CMD_EXEC` the stored code is applied. A further strobe in the same cycle stores the next byte and stays in `CMD_EXEC` (transition EXEC_TO_EXEC). Without one, the machine returns to `CMD_IDLE` (transition EXEC_TO_IDLE). Every effect of a command therefore appears after the second rising edge following the strobe. Byte strobes from the buffer logic advance the pointers directly, one edge after the strobe.

Top module: `pcmd_ctrl`

## Requirements
- R1: After reset, every control output, `frs_req`, `rx_one_more`, `rx_det_clr` and `i2c_err` is 0. `pwr_status` is 0x00 and both pointers hold 1.
- R2: Codes 0x11 and 0xFF change no state. Any code outside the set {0x11,0x22,0x33,0x44,0x55,0x66,0x77,0x88,0x99,0xAA,0xCC,0xDD,0xEE,0xFF} also changes no control state, and it sets `i2c_err`, which stays set until reset.
- R3: Code 0x22 clears `vbus_det_en` and 0x33 sets it. Code 0x44 clears `snk_en`. Code 0x55 sets `snk_en` and also sets `vbus_det_en`.
- R4: Code 0x66 clears `src_en` and `src_hv`. Code 0x77 sets `src_en` and clears `src_hv`. Code 0x88 sets both. `src_hv` is never 1 while `src_en` is 0.
- R5: Code 0x99 sets `look4conn` only when `cfg_drp` is 1. Otherwise it has no effect.
- R6: Code 0xCC gives a one-cycle `frs_req` pulse only when `cfg_is_src` and `cfg_frs_en` are both 1. Otherwise it has no effect.
- R7: Each `tx_byte_we` cycle advances `tx_ptr` by one, stopping at 264. Code 0xDD reloads it to 1, and the reload wins over a byte strobe in the same cycle.
- R8: Each `rx_byte_re` cycle advances `rx_ptr` by one, stopping at 264. Code 0xEE reloads it to 1 when it is 132 or less, and to 133 otherwise.
- R9: Code 0xAA sets `rx_one_more`. While it is set, a `goodcrc_sent` cycle gives a one-cycle `rx_det_clr` pulse and clears `rx_one_more`.
- R10: `pwr_status` carries `snk_en` in bit 0, `vbus_det_en` in bit 3, `src_en` in bit 4 and `src_hv` in bit 5. All other bits are 0.
- R11: A command's effect is visible after the second rising edge following its strobe. It is not visible after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command byte strobe |
| cmd_data | input | 8 | Command byte |
| cfg_drp | input | 1 | Dual-role operation enabled |
| cfg_frs_en | input | 1 | Fast role swap enabled |
| cfg_is_src | input | 1 | Port currently acts as source |
| tx_byte_we | input | 1 | One transmit-buffer byte written |
| rx_byte_re | input | 1 | One receive-buffer byte read |
| goodcrc_sent | input | 1 | A GoodCRC reply has been sent |
| vbus_det_en | output | 1 | VBUS present / safe-zero detection enabled |
| snk_en | output | 1 | Sink path closed |
| src_en | output | 1 | Source path driving VBUS |
| src_hv | output | 1 | Source path at high voltage |
| look4conn | output | 1 | Connection search active |
| frs_req | output | 1 | Fast-role-swap signal request pulse |
| rx_one_more | output | 1 | Auto-clear after next GoodCRC armed |
| rx_det_clr | output | 1 | Pulse clearing receive detection |
| i2c_err | output | 1 | Unrecognised command seen (sticky) |
| pwr_status | output | 8 | Power status byte |
| tx_ptr | output | 9 | Transmit buffer pointer |
| rx_ptr | output | 9 | Receive buffer pointer |

## Verification
The hardest case to reach is the upper branch of the receive reload, because the pointer must be walked past 132 by single read strobes. The stimulus issues exactly 131 and then 132 reads from a fresh reload, and it also runs to saturation before sending 0xEE. This exercises both sides of the boundary and the pointer limit. Beyond that, every one of the 256 command codes is swept from reset and again from a sinking and high-voltage-sourcing state. Each result is compared with an arithmetic model of the control state and of the error flag.

// File: rtl/pcmd_pkg.sv
package pcmd_pkg;
    localparam int BUF_BYTES = 264;
    localparam int BUF_HALF  = 132;
    localparam int PTR_W     = $clog2(BUF_BYTES + 1);

    localparam logic [7:0] OP_WAKE      = 8'h11;
    localparam logic [7:0] OP_DET_OFF   = 8'h22;
    localparam logic [7:0] OP_DET_ON    = 8'h33;
    localparam logic [7:0] OP_SNK_OFF   = 8'h44;
    localparam logic [7:0] OP_SNK_ON    = 8'h55;
    localparam logic [7:0] OP_SRC_OFF   = 8'h66;
    localparam logic [7:0] OP_SRC_DEF   = 8'h77;
    localparam logic [7:0] OP_SRC_HV    = 8'h88;
    localparam logic [7:0] OP_SEARCH    = 8'h99;
    localparam logic [7:0] OP_ONE_MORE  = 8'hAA;
    localparam logic [7:0] OP_FRS       = 8'hCC;
    localparam logic [7:0] OP_TX_RELOAD = 8'hDD;
    localparam logic [7:0] OP_RX_RELOAD = 8'hEE;
    localparam logic [7:0] OP_IDLE      = 8'hFF;

    typedef enum logic {
        CMD_IDLE = 1'b0,
        CMD_EXEC = 1'b1
    } cmd_state_e;

    typedef struct packed {
        logic det;
        logic snk;
        logic src;
        logic hv;
        logic look;
    } ctl_t;
endpackage

// File: rtl/pcmd_bufptr.sv
module pcmd_bufptr #(
    parameter int PW      = 9,
    parameter int LIMIT   = 264,
    parameter bit SPLIT   = 1'b0,
    parameter int HALF    = 132
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          reload,
    output logic [PW-1:0] ptr
);
    localparam logic [PW-1:0] ONE   = PW'(1);
    localparam logic [PW-1:0] TOP   = PW'(LIMIT);
    localparam logic [PW-1:0] UPPER = PW'(HALF + 1);
    localparam logic [PW-1:0] MID   = PW'(HALF);

    logic [PW-1:0] reload_val;

    generate
        if (SPLIT) begin : g_split
            always_comb reload_val = (ptr > MID) ? UPPER : ONE;
        end else begin : g_flat
            always_comb reload_val = ONE;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= ONE;
        end else if (reload) begin
            ptr <= reload_val;
        end else if (step && ptr < TOP) begin
            ptr <= ptr + ONE;
        end
    end
endmodule

// File: rtl/pcmd_fsm.sv
module pcmd_fsm
    import pcmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_we,
    input  logic [7:0] cmd_data,
    input  logic       cfg_drp,
    input  logic       cfg_frs_en,
    input  logic       cfg_is_src,
    input  logic       goodcrc_sent,
    output ctl_t       ctl,
    output logic       frs_req,
    output logic       rx_one_more,
    output logic       rx_det_clr,
    output logic       i2c_err,
    output logic       tx_reload,
    output logic       rx_reload
);
    cmd_state_e state_q, state_d;
    logic [7:0] op_q;
    logic       exec;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CMD_IDLE: if (cmd_we) state_d = CMD_EXEC;
            CMD_EXEC: state_d = cmd_we ? CMD_EXEC : CMD_IDLE;
            default:  state_d = CMD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CMD_IDLE;
            op_q    <= 8'h00;
        end else begin
            state_q <= state_d;
            if (cmd_we) op_q <= cmd_data;
        end
    end

    assign exec      = (state_q == CMD_EXEC);
    assign tx_reload = exec && (op_q == OP_TX_RELOAD);
    assign rx_reload = exec && (op_q == OP_RX_RELOAD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl         <= '0;
            frs_req     <= 1'b0;
            rx_one_more <= 1'b0;
            rx_det_clr  <= 1'b0;
            i2c_err     <= 1'b0;
        end else begin
            frs_req    <= 1'b0;
            rx_det_clr <= 1'b0;
            if (rx_one_more && goodcrc_sent) begin
                rx_det_clr  <= 1'b1;
                rx_one_more <= 1'b0;
            end
            if (exec) begin
                case (op_q)
                    OP_WAKE, OP_IDLE, OP_TX_RELOAD, OP_RX_RELOAD: ;
                    OP_DET_OFF:  ctl.det <= 1'b0;
                    OP_DET_ON:   ctl.det <= 1'b1;
                    OP_SNK_OFF:  ctl.snk <= 1'b0;
                    OP_SNK_ON: begin
                        ctl.snk <= 1'b1;
                        ctl.det <= 1'b1;
                    end
                    OP_SRC_OFF: begin
                        ctl.src <= 1'b0;
                        ctl.hv  <= 1'b0;
                    end
                    OP_SRC_DEF: begin
                        ctl.src <= 1'b1;
                        ctl.hv  <= 1'b0;
                    end
                    OP_SRC_HV: begin
                        ctl.src <= 1'b1;
                        ctl.hv  <= 1'b1;
                    end
                    OP_SEARCH:   if (cfg_drp) ctl.look <= 1'b1;
                    OP_ONE_MORE: rx_one_more <= 1'b1;
                    OP_FRS:      frs_req <= cfg_is_src && cfg_frs_en;
                    default:     i2c_err <= 1'b1;
                endcase
            end
        end
    end
endmodule

// File: rtl/pcmd_ctrl.sv
module pcmd_ctrl
    import pcmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [7:0]       cmd_data,
    input  logic             cfg_drp,
    input  logic             cfg_frs_en,
    input  logic             cfg_is_src,
    input  logic             tx_byte_we,
    input  logic             rx_byte_re,
    input  logic             goodcrc_sent,
    output logic             vbus_det_en,
    output logic             snk_en,
    output logic             src_en,
    output logic             src_hv,
    output logic             look4conn,
    output logic             frs_req,
    output logic             rx_one_more,
    output logic             rx_det_clr,
    output logic             i2c_err,
    output logic [7:0]       pwr_status,
    output logic [PTR_W-1:0] tx_ptr,
    output logic [PTR_W-1:0] rx_ptr
);
    ctl_t ctl;
    logic tx_reload, rx_reload;

    pcmd_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_we       (cmd_we),
        .cmd_data     (cmd_data),
        .cfg_drp      (cfg_drp),
        .cfg_frs_en   (cfg_frs_en),
        .cfg_is_src   (cfg_is_src),
        .goodcrc_sent (goodcrc_sent),
        .ctl          (ctl),
        .frs_req      (frs_req),
        .rx_one_more  (rx_one_more),
        .rx_det_clr   (rx_det_clr),
        .i2c_err      (i2c_err),
        .tx_reload    (tx_reload),
        .rx_reload    (rx_reload)
    );

    pcmd_bufptr #(.PW(PTR_W), .LIMIT(BUF_BYTES), .SPLIT(1'b0), .HALF(BUF_HALF)) u_txp (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (tx_byte_we),
        .reload (tx_reload),
        .ptr    (tx_ptr)
    );

    pcmd_bufptr #(.PW(PTR_W), .LIMIT(BUF_BYTES), .SPLIT(1'b1), .HALF(BUF_HALF)) u_rxp (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (rx_byte_re),
        .reload (rx_reload),
        .ptr    (rx_ptr)
    );

    assign vbus_det_en = ctl.det;
    assign snk_en      = ctl.snk;
    assign src_en      = ctl.src;
    assign src_hv      = ctl.hv;
    assign look4conn   = ctl.look;
    assign pwr_status  = {2'b00, ctl.hv, ctl.src, ctl.det, 2'b00, ctl.snk};
endmodule

// File: rtl/pcmd_ctrl_chk.sv
module pcmd_ctrl_chk
    import pcmd_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_we,
    input logic [7:0]       cmd_data,
    input logic             cfg_drp,
    input logic             cfg_frs_en,
    input logic             cfg_is_src,
    input logic             snk_en,
    input logic             vbus_det_en,
    input logic             src_en,
    input logic             src_hv,
    input logic             look4conn,
    input logic             frs_req,
    input logic             rx_one_more,
    input logic             rx_det_clr,
    input logic [PTR_W-1:0] tx_ptr,
    input logic [PTR_W-1:0] rx_ptr
);
    AST_HV_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        src_hv |-> src_en); // R4
    AST_SNK_WITH_DET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(snk_en) |-> vbus_det_en); // R3
    AST_SEARCH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(look4conn) |-> $past(cfg_drp)); // R5
    AST_FRS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        frs_req |-> $past(cfg_is_src && cfg_frs_en)); // R6
    AST_TX_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ptr >= PTR_W'(1) && tx_ptr <= PTR_W'(BUF_BYTES)); // R7
    AST_RX_RELOAD_VAL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_we && cmd_data == OP_RX_RELOAD, 2) |->
        (rx_ptr == PTR_W'(1) || rx_ptr == PTR_W'(BUF_HALF + 1))); // R8
    AST_DETCLR_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_det_clr |-> $past(rx_one_more)); // R9
endmodule

bind pcmd_ctrl pcmd_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_we      (cmd_we),
    .cmd_data    (cmd_data),
    .cfg_drp     (cfg_drp),
    .cfg_frs_en  (cfg_frs_en),
    .cfg_is_src  (cfg_is_src),
    .snk_en      (snk_en),
    .vbus_det_en (vbus_det_en),
    .src_en      (src_en),
    .src_hv      (src_hv),
    .look4conn   (look4conn),
    .frs_req     (frs_req),
    .rx_one_more (rx_one_more),
    .rx_det_clr  (rx_det_clr),
    .tx_ptr      (tx_ptr),
    .rx_ptr      (rx_ptr)
);

// File: tb/pcmd_ctrl_test.sv
module pcmd_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_we = 1'b0;
    logic [7:0] cmd_data = 8'h00;
    logic cfg_drp = 1'b0, cfg_frs_en = 1'b0, cfg_is_src = 1'b0;
    logic tx_byte_we = 1'b0, rx_byte_re = 1'b0, goodcrc_sent = 1'b0;
    logic vbus_det_en, snk_en, src_en, src_hv, look4conn, frs_req;
    logic rx_one_more, rx_det_clr, i2c_err;
    logic [7:0] pwr_status;
    logic [8:0] tx_ptr, rx_ptr;

    int n_checks = 0;
    int n_fail = 0;

    logic m_det, m_snk, m_src, m_hv, m_look, m_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcmd_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
        .cfg_drp(cfg_drp), .cfg_frs_en(cfg_frs_en), .cfg_is_src(cfg_is_src),
        .tx_byte_we(tx_byte_we), .rx_byte_re(rx_byte_re), .goodcrc_sent(goodcrc_sent),
        .vbus_det_en(vbus_det_en), .snk_en(snk_en), .src_en(src_en), .src_hv(src_hv),
        .look4conn(look4conn), .frs_req(frs_req), .rx_one_more(rx_one_more),
        .rx_det_clr(rx_det_clr), .i2c_err(i2c_err), .pwr_status(pwr_status),
        .tx_ptr(tx_ptr), .rx_ptr(rx_ptr)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        {m_det, m_snk, m_src, m_hv, m_look, m_err} = '0;
        @(negedge clk);
    endtask

    function automatic bit known(input logic [7:0] c);
        case (c)
            8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77,
            8'h88, 8'h99, 8'hAA, 8'hCC, 8'hDD, 8'hEE, 8'hFF: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic model(input logic [7:0] c);
        case (c)
            8'h22: m_det = 1'b0;
            8'h33: m_det = 1'b1;
            8'h44: m_snk = 1'b0;
            8'h55: begin m_snk = 1'b1; m_det = 1'b1; end
            8'h66: begin m_src = 1'b0; m_hv = 1'b0; end
            8'h77: begin m_src = 1'b1; m_hv = 1'b0; end
            8'h88: begin m_src = 1'b1; m_hv = 1'b1; end
            8'h99: if (cfg_drp) m_look = 1'b1;
            default: ;
        endcase
        if (!known(c)) m_err = 1'b1;
    endtask

    // drive at a falling edge; effect lands two rising edges later
    task automatic send(input logic [7:0] c);
        cmd_we = 1'b1;
        cmd_data = c;
        @(negedge clk);
        cmd_we = 1'b0;
        @(negedge clk);
        model(c);
    endtask

    function automatic int exp_status();
        return (int'(m_hv) << 5) | (int'(m_src) << 4) | (int'(m_det) << 3) | int'(m_snk);
    endfunction

    task automatic tx_bytes(input int n);
        for (int i = 0; i < n; i++) begin
            tx_byte_we = 1'b1;
            @(negedge clk);
        end
        tx_byte_we = 1'b0;
    endtask

    task automatic rx_bytes(input int n);
        for (int i = 0; i < n; i++) begin
            rx_byte_re = 1'b1;
            @(negedge clk);
        end
        rx_byte_re = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 pwr_status", int'(pwr_status), 0);
        check("R1 tx_ptr", int'(tx_ptr), 1);
        check("R1 rx_ptr", int'(rx_ptr), 1);
        check("R1 flags", int'({look4conn, frs_req, rx_one_more, rx_det_clr, i2c_err}), 0);

        // R11 timing: not visible after first edge, visible after second
        cmd_we = 1'b1; cmd_data = 8'h55;
        @(negedge clk);
        cmd_we = 1'b0;
        check("R11 snk_en after one edge", int'(snk_en), 0);
        @(negedge clk);
        check("R11 snk_en after two edges", int'(snk_en), 1);

        // R2, R3, R4, R5, R10 sweep of all codes, from reset and from a loaded state
        cfg_drp = 1'b1;
        for (int pass = 0; pass < 2; pass++) begin
            for (int c = 0; c < 256; c++) begin
                do_reset();
                if (pass == 1) begin
                    send(8'h55);
                    send(8'h88);
                end
                send(8'(c));
                check("R10 pwr_status sweep", int'(pwr_status), exp_status());
                check("R3 R4 path levels", int'({vbus_det_en, snk_en, src_en, src_hv}),
                      int'({m_det, m_snk, m_src, m_hv}));
                check("R2 i2c_err sweep", int'(i2c_err), int'(m_err));
                check("R5 look4conn sweep", int'(look4conn), int'(m_look));
            end
        end

        // R2 sticky error survives later valid commands
        do_reset();
        send(8'h5A);
        send(8'h33);
        check("R2 i2c_err sticky", int'(i2c_err), 1);
        check("R2 no state from bad code", int'(pwr_status), 8'h08);

        // R5 search gated by dual-role
        do_reset();
        cfg_drp = 1'b0;
        send(8'h99);
        check("R5 no search without drp", int'(look4conn), 0);
        cfg_drp = 1'b1;
        send(8'h99);
        check("R5 search with drp", int'(look4conn), 1);

        // R6 fast role swap gating
        cfg_is_src = 1'b1; cfg_frs_en = 1'b0;
        send(8'hCC);
        check("R6 frs blocked when disabled", int'(frs_req), 0);
        cfg_is_src = 1'b0; cfg_frs_en = 1'b1;
        send(8'hCC);
        check("R6 frs blocked when sink", int'(frs_req), 0);
        cfg_is_src = 1'b1;
        send(8'hCC);
        check("R6 frs pulse", int'(frs_req), 1);
        @(negedge clk);
        check("R6 frs single cycle", int'(frs_req), 0);

        // R7 transmit pointer
        do_reset();
        tx_bytes(10);
        check("R7 tx advance", int'(tx_ptr), 11);
        tx_bytes(300);
        check("R7 tx saturate", int'(tx_ptr), 264);
        send(8'hDD);
        check("R7 tx reload", int'(tx_ptr), 1);
        tx_bytes(5);
        cmd_we = 1'b1; cmd_data = 8'hDD;
        @(negedge clk);
        cmd_we = 1'b0; tx_byte_we = 1'b1;
        @(negedge clk);
        tx_byte_we = 1'b0;
        check("R7 reload beats strobe", int'(tx_ptr), 1);

        // R8 receive pointer with split reload
        do_reset();
        rx_bytes(131);
        check("R8 rx at 132", int'(rx_ptr), 132);
        send(8'hEE);
        check("R8 reload lower half", int'(rx_ptr), 1);
        rx_bytes(132);
        check("R8 rx at 133", int'(rx_ptr), 133);
        send(8'hEE);
        check("R8 reload upper half", int'(rx_ptr), 133);
        rx_bytes(200);
        check("R8 rx saturate", int'(rx_ptr), 264);
        send(8'hEE);
        check("R8 reload from top", int'(rx_ptr), 133);

        // R9 one-more arming
        do_reset();
        goodcrc_sent = 1'b1;
        @(negedge clk);
        goodcrc_sent = 1'b0;
        check("R9 no clear when unarmed", int'(rx_det_clr), 0);
        send(8'hAA);
        check("R9 armed", int'(rx_one_more), 1);
        goodcrc_sent = 1'b1;
        @(negedge clk);
        goodcrc_sent = 1'b0;
        check("R9 clear pulse", int'(rx_det_clr), 1);
        check("R9 disarmed", int'(rx_one_more), 0);
        @(negedge clk);
        check("R9 pulse ends", int'(rx_det_clr), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule